// File: doc/BRIEF.md
# Event Timestamp Latch Bank

This block holds event timestamps for a host. When the packet front end decodes a timing event frame, it raises a start-of-frame strobe together with the frame's protocol version, its transport (UDP or raw layer 2) and its message type. If the receive filter accepts the frame, the block copies the free-running 64-bit nanosecond time into one of several receive slots. It also reports which slot it used, so that the index can travel with the packet to its receive descriptor. A separate single transmit latch captures the time at which an outgoing event frame left. It can raise an interrupt.

Software reads each 64-bit value as two 32-bit words through a small register port. A slot stays locked from the moment of capture until its high word is read, and no later frame can overwrite it. When every receive slot is locked, accepted frames are counted as drops and get no timestamp. The filter has no separate off switch. Selecting version 1 with UDP recognition disabled suppresses every receive capture.

Top module: `ts_latch_bank`

## Requirements
- R1: A receive capture happens only in a cycle with rx_sof_i high, rx_ver2_i equal to control bit 1 (1 = version 2 mode), and control bit 16+rx_msg_type_i (message-type mask) set.
- R2: A frame with rx_udp_i high needs control bit 2 (UDP recognition) set. A frame with rx_udp_i low is accepted only when it is a version 2 frame. Version 1 mode with bit 2 clear therefore captures nothing.
- R3: A capture stores the time_i value present in the strobe cycle. In the following cycle rx_cap_o pulses for one cycle with the slot index on rx_slot_o, and bit k of the status register (address 1) is set.
- R4: A frame that qualifies while every receive slot is locked is not captured. Instead the drop counter (address 3) increments, saturating at 2^DROP_W-1.
- R5: The free slot with the lowest index is used. Allocation sees slot state as it was at the start of the strobe cycle.
- R6: Slot k reads at address 8+2k (low word) and 9+2k (high word). Reading the high word releases the slot and clears its status bit. Reading the low word does not.
- R7: tx_sof_i captures time_i into the transmit latch only when the latch is empty. While it is locked, further strobes are ignored. It reads at address 4 (low) and 5 (high), and reading the high word releases it.
- R8: A transmit capture sets the pending bit (bit 0 of address 2). irq_o is pending AND control bit 0. Reading address 2 returns the pending bit and clears it.
- R9: Register reads return data on reg_rdata_o in the cycle after reg_rd_i. The control word at address 0 reads back as written. Reset clears control, slots, counters and outputs.
- R10: Bit 1 of address 2 shows whether the transmit latch is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current nanosecond time |
| rx_sof_i | input | 1 | Decoded receive event frame strobe |
| rx_ver2_i | input | 1 | Frame is protocol version 2 |
| rx_udp_i | input | 1 | Frame carried over UDP |
| rx_msg_type_i | input | 4 | Frame message type |
| tx_sof_i | input | 1 | Transmit event frame strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| rx_cap_o | output | 1 | Receive capture made (one cycle) |
| rx_slot_o | output | 2 | Slot index of that capture |
| irq_o | output | 1 | Transmit timestamp interrupt |

## Verification
The assertions assume three things about the inputs. Strobes and register accesses are single-cycle and synchronous. A slot's high word is read only after its low word, if the value is wanted at all. time_i is stable around the sampling edge. The bench drives every strobe and access on the falling edge for exactly one cycle and holds time_i at a distinct value per event, so any value read back identifies the cycle it was captured in. It never issues a read and a capture in the same cycle, which keeps the same-cycle allocation rule out of the expected values.

// File: rtl/ts_bank_pkg.sv
package ts_bank_pkg;
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_RXSTAT  = 1;
  localparam int ADDR_EVENT   = 2;
  localparam int ADDR_DROP    = 3;
  localparam int ADDR_TXLO    = 4;
  localparam int ADDR_TXHI    = 5;
  localparam int ADDR_RX_BASE = 8;

  localparam int CTRL_IRQ_EN   = 0;
  localparam int CTRL_VER2     = 1;
  localparam int CTRL_UDP_EN   = 2;
  localparam int CTRL_MASK_LSB = 16;
endpackage

// File: rtl/ts_rx_filter.sv
module ts_rx_filter #(
  parameter int MSG_W = 4,
  localparam int MASK_W = 1 << MSG_W
) (
  input  logic              sof_i,
  input  logic              frame_ver2_i,
  input  logic              frame_udp_i,
  input  logic [MSG_W-1:0]  msg_type_i,
  input  logic              cfg_ver2_i,
  input  logic              cfg_udp_en_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o
);
  logic ver_ok, type_ok, xport_ok;

  assign ver_ok   = frame_ver2_i == cfg_ver2_i;
  assign type_ok  = mask_i[msg_type_i];
  // raw layer-2 transport only exists for version 2
  assign xport_ok = frame_udp_i ? cfg_udp_en_i : frame_ver2_i;
  assign hit_o    = sof_i && ver_ok && type_ok && xport_ok;
endmodule

// File: rtl/ts_slot_alloc.sv
module ts_slot_alloc #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     busy_i,
  output logic             any_free_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  assign any_free_o = ~&busy_i;

  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!busy_i[k]) idx_o = IDX_W'(k);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant_o[g] = any_free_o && (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/ts_slot.sv
module ts_slot #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              rel_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] value_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      value_o <= '0;
    end else if (rel_i) begin
      valid_o <= 1'b0;
    end else if (cap_i && !valid_o) begin
      valid_o <= 1'b1;
      value_o <= time_i;
    end
  end
endmodule

// File: rtl/ts_latch_bank.sv
module ts_latch_bank
  import ts_bank_pkg::*;
#(
  parameter int NUM_RX = 4,
  parameter int REG_W  = 32,
  parameter int MSG_W  = 4,
  parameter int DROP_W = 8,
  parameter int ADDR_W = 5,
  localparam int TIME_W = 2 * REG_W,
  localparam int IDX_W  = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rx_sof_i,
  input  logic              rx_ver2_i,
  input  logic              rx_udp_i,
  input  logic [MSG_W-1:0]  rx_msg_type_i,
  input  logic              tx_sof_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              rx_cap_o,
  output logic [IDX_W-1:0]  rx_slot_o,
  output logic              irq_o
);
  localparam int MASK_W = 1 << MSG_W;

  logic [REG_W-1:0] ctrl_q;
  logic             rx_hit, any_free, rx_take, rx_miss;
  logic [IDX_W-1:0] alloc_idx;
  logic [NUM_RX-1:0] alloc_grant, rx_valid, rx_rel;
  logic [NUM_RX-1:0][TIME_W-1:0] rx_val;
  logic              tx_valid, tx_rel, tx_take;
  logic [TIME_W-1:0] tx_val;
  logic              pend_q, ev_rd;
  logic [DROP_W-1:0] drop_q;
  logic [REG_W-1:0]  rd_mux;

  // control word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_CTRL)) ctrl_q <= reg_wdata_i;
  end

  ts_rx_filter #(.MSG_W(MSG_W)) u_filter (
    .sof_i        (rx_sof_i),
    .frame_ver2_i (rx_ver2_i),
    .frame_udp_i  (rx_udp_i),
    .msg_type_i   (rx_msg_type_i),
    .cfg_ver2_i   (ctrl_q[CTRL_VER2]),
    .cfg_udp_en_i (ctrl_q[CTRL_UDP_EN]),
    .mask_i       (ctrl_q[CTRL_MASK_LSB +: MASK_W]),
    .hit_o        (rx_hit)
  );

  ts_slot_alloc #(.N(NUM_RX)) u_alloc (
    .busy_i     (rx_valid),
    .any_free_o (any_free),
    .idx_o      (alloc_idx),
    .grant_o    (alloc_grant)
  );

  assign rx_take = rx_hit && any_free;
  assign rx_miss = rx_hit && !any_free;

  for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
    assign rx_rel[g] = reg_rd_i && (reg_addr_i == ADDR_W'(ADDR_RX_BASE + 2 * g + 1));
    ts_slot #(.TIME_W(TIME_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (rx_take && alloc_grant[g]),
      .rel_i   (rx_rel[g]),
      .time_i  (time_i),
      .valid_o (rx_valid[g]),
      .value_o (rx_val[g])
    );
  end

  assign tx_rel  = reg_rd_i && (reg_addr_i == ADDR_W'(ADDR_TXHI));
  assign tx_take = tx_sof_i && !tx_valid;

  ts_slot #(.TIME_W(TIME_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (tx_sof_i),
    .rel_i   (tx_rel),
    .time_i  (time_i),
    .valid_o (tx_valid),
    .value_o (tx_val)
  );

  assign ev_rd = reg_rd_i && (reg_addr_i == ADDR_W'(ADDR_EVENT));

  // new capture wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (tx_take) pend_q <= 1'b1;
    else if (ev_rd)   pend_q <= 1'b0;
  end

  assign irq_o = pend_q && ctrl_q[CTRL_IRQ_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= '0;
    else if (rx_miss && drop_q != {DROP_W{1'b1}}) drop_q <= drop_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cap_o  <= 1'b0;
      rx_slot_o <= '0;
    end else begin
      rx_cap_o  <= rx_take;
      if (rx_take) rx_slot_o <= alloc_idx;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL))   rd_mux = ctrl_q;
    if (reg_addr_i == ADDR_W'(ADDR_RXSTAT)) rd_mux = REG_W'(rx_valid);
    if (reg_addr_i == ADDR_W'(ADDR_EVENT))  rd_mux = REG_W'({tx_valid, pend_q});
    if (reg_addr_i == ADDR_W'(ADDR_DROP))   rd_mux = REG_W'(drop_q);
    if (reg_addr_i == ADDR_W'(ADDR_TXLO))   rd_mux = tx_val[REG_W-1:0];
    if (reg_addr_i == ADDR_W'(ADDR_TXHI))   rd_mux = tx_val[TIME_W-1:REG_W];
    for (int k = 0; k < NUM_RX; k++) begin
      if (reg_addr_i == ADDR_W'(ADDR_RX_BASE + 2 * k))     rd_mux = rx_val[k][REG_W-1:0];
      if (reg_addr_i == ADDR_W'(ADDR_RX_BASE + 2 * k + 1)) rd_mux = rx_val[k][TIME_W-1:REG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/ts_latch_bank_chk.sv
module ts_latch_bank_chk #(
  parameter int NUM_RX = 4,
  parameter int IDX_W  = 2,
  parameter int TIME_W = 64,
  parameter int DROP_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rx_cap_o,
  input logic [IDX_W-1:0]              rx_slot_o,
  input logic [NUM_RX-1:0]             rx_valid,
  input logic [NUM_RX-1:0]             rx_rel,
  input logic [NUM_RX-1:0][TIME_W-1:0] rx_val,
  input logic                          tx_valid,
  input logic                          tx_rel,
  input logic [TIME_W-1:0]             tx_val,
  input logic [DROP_W-1:0]             drop_q
);
  logic [NUM_RX-1:0] below;

  always_comb begin
    for (int k = 0; k < NUM_RX; k++) below[k] = (k < int'(rx_slot_o));
  end

  AST_CAP_INTO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cap_o |-> ($past(rx_valid) != {NUM_RX{1'b1}})); // R4

  AST_CAP_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cap_o |-> (($past(rx_valid) & below) == below)); // R5

  AST_CAP_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cap_o |-> rx_valid[rx_slot_o]); // R3

  AST_DROP_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q >= $past(drop_q)); // R4

  AST_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid && !tx_rel) |=> (tx_valid && $stable(tx_val))); // R7

  for (genvar g = 0; g < NUM_RX; g++) begin : g_held
    AST_RX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid[g] && !rx_rel[g]) |=> (rx_valid[g] && $stable(rx_val[g]))); // R6
  end
endmodule

bind ts_latch_bank ts_latch_bank_chk #(
  .NUM_RX (NUM_RX),
  .IDX_W  (IDX_W),
  .TIME_W (TIME_W),
  .DROP_W (DROP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_cap_o  (rx_cap_o),
  .rx_slot_o (rx_slot_o),
  .rx_valid  (rx_valid),
  .rx_rel    (rx_rel),
  .rx_val    (rx_val),
  .tx_valid  (tx_valid),
  .tx_rel    (tx_rel),
  .tx_val    (tx_val),
  .drop_q    (drop_q)
);

// File: tb/ts_latch_bank_tb_top.sv
module ts_latch_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_v = '0;
  logic        rx_sof = 1'b0, rx_ver2 = 1'b0, rx_udp = 1'b0, tx_sof = 1'b0;
  logic [3:0]  rx_mt = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_cap, irq;
  logic [1:0]  rx_slot;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ts_latch_bank dut_i (
    .clk_i (clk), .rst_ni (rst_n), .time_i (time_v),
    .rx_sof_i (rx_sof), .rx_ver2_i (rx_ver2), .rx_udp_i (rx_udp), .rx_msg_type_i (rx_mt),
    .tx_sof_i (tx_sof), .reg_wr_i (reg_wr), .reg_rd_i (reg_rd), .reg_addr_i (reg_addr),
    .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata), .rx_cap_o (rx_cap),
    .rx_slot_o (rx_slot), .irq_o (irq)
  );

  // cfg_v2, cfg_udp, mask_on, frame_v2, frame_udp, expected capture
  localparam logic [5:0] VEC [9] = '{
    6'b111111, 6'b101110, 6'b101101, 6'b110100, 6'b011011,
    6'b001010, 6'b011110, 6'b111010, 6'b011000
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 5'(a);
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rx_send(input logic v2, input logic udp, input logic [3:0] mt, input logic [63:0] t,
                         output logic cap, output logic [1:0] slot);
    @(negedge clk); rx_sof = 1'b1; rx_ver2 = v2; rx_udp = udp; rx_mt = mt; time_v = t;
    @(negedge clk); rx_sof = 1'b0; time_v = ~t; cap = rx_cap; slot = rx_slot;
  endtask

  task automatic tx_send(input logic [63:0] t);
    @(negedge clk); tx_sof = 1'b1; time_v = t;
    @(negedge clk); tx_sof = 1'b0; time_v = ~t;
  endtask

  function automatic logic [31:0] ctrl_word(logic irq_en, logic v2, logic udp, logic [15:0] mask);
    return {mask, 13'b0, udp, v2, irq_en};
  endfunction

  function automatic logic [63:0] stamp(int k);
    return {32'hA000_0000 + 32'(k), 32'h5000_0000 + 32'(k)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic cap;
    logic [1:0] slot;

    repeat (3) @(negedge clk);
    check("R9", "rdata in reset", 64'(reg_rdata), 64'h0);
    rst_n = 1'b1;
    check("R9", "rx_cap after reset", 64'(rx_cap), 64'h0);
    check("R9", "irq after reset", 64'(irq), 64'h0);
    rd(1, d); check("R9", "status after reset", 64'(d), 64'h0);
    rd(3, d); check("R9", "drops after reset", 64'(d), 64'h0);

    // filter table: R1 R2
    for (int i = 0; i < 9; i++) begin
      logic [3:0] mt;
      logic [15:0] mask;
      mt = 4'(i * 3 + 1);
      mask = VEC[i][3] ? (16'h1 << mt) : ~(16'h1 << mt);
      wr(0, ctrl_word(1'b0, VEC[i][5], VEC[i][4], mask));
      rx_send(VEC[i][2], VEC[i][1], mt, stamp(100 + i), cap, slot);
      check("R1 R2", $sformatf("vector %0d capture", i), 64'(cap), 64'(VEC[i][0]));
      if (cap) begin
        check("R5", "slot when empty", 64'(slot), 64'h0);
        rd(8, d); check("R3", "captured low", 64'(d), 64'(stamp(100 + i) & 64'hFFFF_FFFF));
        rd(9, d); check("R6", "captured high", 64'(d), stamp(100 + i) >> 32);
      end
      rd(1, d); check("R6", "status after vector", 64'(d), 64'h0);
    end

    wr(0, ctrl_word(1'b0, 1'b1, 1'b1, 16'hFFFF));
    rd(0, d); check("R9", "ctrl readback", 64'(d), 64'(ctrl_word(1'b0, 1'b1, 1'b1, 16'hFFFF)));

    for (int k = 0; k < 4; k++) begin
      rx_send(1'b1, 1'b0, 4'(k), stamp(k), cap, slot);
      check("R3", "fill capture", 64'(cap), 64'h1);
      check("R5", "fill order", 64'(slot), 64'(k));
    end
    rd(1, d); check("R3", "status full", 64'(d), 64'hF);
    rd(10, d); check("R6", "slot1 low", 64'(d), 64'(stamp(1) & 64'hFFFF_FFFF));
    rd(1, d); check("R6", "low read keeps lock", 64'(d), 64'hF);

    rx_send(1'b1, 1'b1, 4'd7, stamp(50), cap, slot);
    check("R4", "full bank no capture", 64'(cap), 64'h0);
    rd(3, d); check("R4", "drop count", 64'(d), 64'h1);

    rd(13, d); check("R6", "slot2 high", 64'(d), stamp(2) >> 32);
    rd(1, d); check("R6", "slot2 released", 64'(d), 64'hB);
    rx_send(1'b1, 1'b1, 4'd3, stamp(4), cap, slot);
    check("R5", "refill lowest free", 64'(slot), 64'h2);
    rd(12, d); check("R3", "new slot2 low", 64'(d), 64'(stamp(4) & 64'hFFFF_FFFF));
    rd(13, d); check("R3", "new slot2 high", 64'(d), stamp(4) >> 32);
    rd(0, d);

    rx_send(1'b1, 1'b1, 4'd3, stamp(5), cap, slot);
    for (int n = 0; n < 300; n++) rx_send(1'b1, 1'b0, 4'd1, stamp(6), cap, slot);
    rd(3, d); check("R4", "drop saturation", 64'(d), 64'hFF);
    rd(8, d); check("R6", "slot0 untouched by drops", 64'(d), 64'(stamp(0) & 64'hFFFF_FFFF));

    // transmit latch
    rd(2, d); check("R10", "event idle", 64'(d), 64'h0);
    tx_send(stamp(200));
    check("R8", "irq masked", 64'(irq), 64'h0);
    rd(2, d); check("R8", "pending and locked", 64'(d), 64'h3);
    rd(2, d); check("R8", "pending cleared by read", 64'(d), 64'h2);
    tx_send(stamp(201));
    rd(4, d); check("R7", "tx low kept", 64'(d), 64'(stamp(200) & 64'hFFFF_FFFF));
    rd(2, d); check("R7", "ignored strobe no pending", 64'(d), 64'h2);
    rd(5, d); check("R7", "tx high", 64'(d), stamp(200) >> 32);
    rd(2, d); check("R10", "tx released", 64'(d), 64'h0);

    wr(0, ctrl_word(1'b1, 1'b1, 1'b1, 16'hFFFF));
    tx_send(stamp(202));
    check("R8", "irq raised", 64'(irq), 64'h1);
    rd(2, d); check("R8", "event read", 64'(d), 64'h3);
    check("R8", "irq cleared", 64'(irq), 64'h0);
    rd(4, d); check("R7", "new tx low", 64'(d), 64'(stamp(202) & 64'hFFFF_FFFF));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule